// File: doc/BRIEF.md
# Mixed-Rate TDM Access Scheduler

This block orders the byte accesses that a serial-to-parallel converter makes to an external dual-port memory when two stream rates share one frame. Eight fast streams (numbered 16 to 23) carry 128 channels per frame. Sixteen slow streams (numbered 0 to 15) carry 32 channels per frame. Every 32 port-clock cycles the block issues a burst of 12 writes, waits 4 cycles, issues a burst of 12 reads, then waits 4 more cycles. Each burst serves all eight fast streams for one channel. It then serves one group of four slow streams, and the group advances every burst period. So four fast channel periods make up one slow channel period.

Each access comes with its stream number, channel number and 13-bit memory address. Data written to memory (received from the serial side) lags the data read from memory (sent to the serial side). The lag is eight channels on the fast streams and two channels on the slow ones. Two toggling flags say which half of the memory each direction is using. This lets software double-buffer whole frames.

The frame pulse is accepted only when it is high at a rising edge of a slower reference clock. That reference clock is sampled in the port-clock domain.

Top module: `mixed_rate_tdm_sched`

## Requirements
- R1: After reset, `acc_valid` stays low until the first accepted frame pulse.
- R2: The frame pulse is accepted only when `frame_pulse` is high on the first port-clock edge at which `ref_clk` is seen high after being low. A pulse at any other time has no effect on the outputs.
- R3: In the cycle after an accepted pulse the schedule starts at phase 0, and it repeats every 32 cycles. Phases 0–11 are writes (`acc_write`=1), 12–15 are idle, 16–27 are reads (`acc_write`=0) and 28–31 are idle (`acc_valid`=0).
- R4: In each burst the first eight accesses go to streams 16, 17, …, 23 in order. The last four go to slow streams in ascending order.
- R5: In a burst that belongs to fast channel c, the slow streams served are 4·(c mod 4) to 4·(c mod 4)+3, on slow channel c/4 (integer division).
- R6: In burst period h (0..127 from the frame start), reads use fast channel h. Writes use fast channel (h−8) mod 128. R5 applied to that channel gives a slow write channel two below the slow read channel, modulo 32.
- R7: Address bits 11:0 are 16·channel + stream for slow accesses, and 8·channel + (stream−16) + 400h for fast accesses. Writes add 800h.
- R8: Address bit 12 equals `wr_blk` for writes and `rd_blk` for reads.
- R9: `rd_blk` inverts after the last read of burst period 127. `wr_blk` inverts after the last write of burst period 7, which is the last write of fast channel 127. No other event changes either flag.
- R10: A frame pulse accepted mid-frame restarts the schedule at period 0, phase 0 in the next cycle, and leaves both flags unchanged.
- R11: While reset is low, `acc_valid`, `rd_blk` and `wr_blk` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock, sampled by `clk` |
| frame_pulse | input | 1 | Frame marker, active high |
| acc_valid | output | 1 | A memory access happens this cycle |
| acc_write | output | 1 | 1 = write to memory, 0 = read from memory |
| stream_sel | output | 5 | Serial stream of the access |
| chan_sel | output | 7 | Channel within that stream |
| mem_addr | output | 13 | Memory byte address |
| rd_blk | output | 1 | Memory half used by reads |
| wr_blk | output | 1 | Memory half used by writes |

## Verification
An accepted pulse moves the registered slot position on the same port-clock edge. Every access output is decoded from that position with no input on the path, so each result is due in the cycle that follows the edge that produced it. A flag inversion first shows in the phase after the last access of its burst. The bench steps a behavioural frame-time model on each rising edge. It compares all outputs 1 ns after the following falling edge, which keeps the comparison clear of input changes. Directed checks cover the cycles just after reset, a rejected pulse, and a mid-frame restart.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int HI_N    = 8;
  localparam int LO_Q    = 4;
  localparam int N_QTR   = 4;
  localparam int HI_CH   = 128;
  localparam int IDLE    = 4;
  localparam int HI_LAG  = 8;
  localparam int LO_N    = LO_Q * N_QTR;
  localparam int LO_CH   = HI_CH / N_QTR;
  localparam int BURST   = HI_N + LO_Q;
  localparam int HALF    = BURST + IDLE;
  localparam int PERIOD  = 2 * HALF;
  localparam int PH_W    = $clog2(PERIOD);
  localparam int PER_W   = $clog2(HI_CH);
  localparam int ST_W    = $clog2(LO_N + HI_N);
  localparam int CH_W    = PER_W;
  localparam int BLK_BIT = 12;
  localparam int AD_W    = BLK_BIT + 1;
  localparam int HI_OFS  = 'h400;
  localparam int RX_OFS  = 'h800;

  // byte address of one access
  function automatic int slot_addr(input bit is_hi, input int ch, input int lane,
                                   input bit rx, input bit blk);
    int stride;
    stride = is_hi ? HI_N : LO_N;
    return (is_hi ? HI_OFS : 0) + (rx ? RX_OFS : 0) + (blk ? (1 << BLK_BIT) : 0)
           + ch * stride + lane;
  endfunction

  // slow-stream group served in a given fast channel period
  function automatic int quarter_of(input int fast_ch);
    return fast_ch % N_QTR;
  endfunction
endpackage

// File: rtl/mrs_frame_qual.sv
module mrs_frame_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic frame_pulse,
  output logic fp_hit
);
  logic ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b1;
    else        ref_q <= ref_clk;
  end

  assign fp_hit = ref_clk & ~ref_q & frame_pulse;
endmodule

// File: rtl/mrs_slot_counter.sv
module mrs_slot_counter
  import mrs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_hit,
  output logic             run,
  output logic [PER_W-1:0] period,
  output logic [PH_W-1:0]  phase,
  output logic             rd_blk,
  output logic             wr_blk,
  output logic             rd_done,
  output logic             wr_done
);
  logic ph_last;

  assign ph_last = (phase == PH_W'(PERIOD - 1));
  assign rd_done = run && (period == PER_W'(HI_CH - 1)) && (phase == PH_W'(HALF + BURST - 1));
  assign wr_done = run && (period == PER_W'(HI_LAG - 1)) && (phase == PH_W'(BURST - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      period <= '0;
      phase  <= '0;
      rd_blk <= 1'b0;
      wr_blk <= 1'b0;
    end else begin
      if (fp_hit) begin
        run    <= 1'b1;
        period <= '0;
        phase  <= '0;
      end else if (run) begin
        phase <= ph_last ? '0 : phase + 1'b1;
        if (ph_last)
          period <= (period == PER_W'(HI_CH - 1)) ? '0 : period + 1'b1;
      end
      if (rd_done) rd_blk <= ~rd_blk;
      if (wr_done) wr_blk <= ~wr_blk;
    end
  end
endmodule

// File: rtl/mrs_addr_gen.sv
module mrs_addr_gen
  import mrs_pkg::*;
(
  input  logic             run,
  input  logic [PER_W-1:0] period,
  input  logic [PH_W-1:0]  phase,
  input  logic             rd_blk,
  input  logic             wr_blk,
  output logic             acc_valid,
  output logic             acc_write,
  output logic [ST_W-1:0]  stream_sel,
  output logic [CH_W-1:0]  chan_sel,
  output logic [AD_W-1:0]  mem_addr
);
  always_comb begin
    int  ph, k, base, lane, slow_ch;
    logic in_wr, in_rd, blk;
    ph      = int'(phase);
    in_wr   = ph < BURST;
    in_rd   = (ph >= HALF) && (ph < HALF + BURST);
    k       = in_wr ? ph : ph - HALF;
    base    = in_wr ? (int'(period) + HI_CH - HI_LAG) % HI_CH : int'(period);
    blk     = in_wr ? wr_blk : rd_blk;
    slow_ch = base / N_QTR;
    lane    = quarter_of(base) * LO_Q + k - HI_N;
    acc_valid  = 1'b0;
    acc_write  = 1'b0;
    stream_sel = '0;
    chan_sel   = '0;
    mem_addr   = '0;
    if (run && (in_wr || in_rd)) begin
      acc_valid = 1'b1;
      acc_write = in_wr;
      if (k < HI_N) begin
        stream_sel = ST_W'(LO_N + k);
        chan_sel   = CH_W'(base);
        mem_addr   = AD_W'(slot_addr(1'b1, base, k, in_wr, blk));
      end else begin
        stream_sel = ST_W'(lane);
        chan_sel   = CH_W'(slow_ch);
        mem_addr   = AD_W'(slot_addr(1'b0, slow_ch, lane, in_wr, blk));
      end
    end
  end
endmodule

// File: rtl/mixed_rate_tdm_sched.sv
module mixed_rate_tdm_sched
  import mrs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_clk,
  input  logic            frame_pulse,
  output logic            acc_valid,
  output logic            acc_write,
  output logic [ST_W-1:0] stream_sel,
  output logic [CH_W-1:0] chan_sel,
  output logic [AD_W-1:0] mem_addr,
  output logic            rd_blk,
  output logic            wr_blk
);
  logic             fp_hit;
  logic             sched_run;
  logic [PER_W-1:0] period;
  logic [PH_W-1:0]  phase;
  logic             rd_done;
  logic             wr_done;

  mrs_frame_qual u_qual (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
    .frame_pulse(frame_pulse), .fp_hit(fp_hit)
  );

  mrs_slot_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .fp_hit(fp_hit), .run(sched_run),
    .period(period), .phase(phase), .rd_blk(rd_blk), .wr_blk(wr_blk),
    .rd_done(rd_done), .wr_done(wr_done)
  );

  mrs_addr_gen u_addr (
    .run(sched_run), .period(period), .phase(phase),
    .rd_blk(rd_blk), .wr_blk(wr_blk),
    .acc_valid(acc_valid), .acc_write(acc_write),
    .stream_sel(stream_sel), .chan_sel(chan_sel), .mem_addr(mem_addr)
  );
endmodule

// File: rtl/mrs_sched_chk.sv
module mrs_sched_chk
  import mrs_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            fp_hit,
  input logic            sched_run,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [ST_W-1:0] stream_sel,
  input logic [CH_W-1:0] chan_sel,
  input logic [AD_W-1:0] mem_addr,
  input logic            rd_blk,
  input logic            wr_blk
);
  assert_no_access_unsynced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_run |-> !acc_valid);

  assert_fast_stream_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !fp_hit && stream_sel >= ST_W'(LO_N) && stream_sel < ST_W'(LO_N + HI_N - 1))
    |=> (acc_valid && stream_sel == $past(stream_sel) + 1'b1));

  assert_block_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (mem_addr[BLK_BIT] == (acc_write ? wr_blk : rd_blk)));

  assert_rd_flag_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_blk) |-> $past(acc_valid && !acc_write &&
                               stream_sel == ST_W'(LO_N - 1) && chan_sel == CH_W'(LO_CH - 1)));

  assert_wr_flag_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_blk) |-> $past(acc_valid && acc_write &&
                               stream_sel == ST_W'(LO_N - 1) && chan_sel == CH_W'(LO_CH - 1)));
endmodule

bind mixed_rate_tdm_sched mrs_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fp_hit(fp_hit), .sched_run(sched_run),
  .acc_valid(acc_valid), .acc_write(acc_write), .stream_sel(stream_sel),
  .chan_sel(chan_sel), .mem_addr(mem_addr), .rd_blk(rd_blk), .wr_blk(wr_blk)
);

// File: tb/sim_mixed_rate_tdm_sched.sv
`timescale 1ns/1ps
module sim_mixed_rate_tdm_sched;
  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, frame_pulse = 1'b0;
  logic acc_valid, acc_write, rd_blk, wr_blk;
  logic [4:0] stream_sel;
  logic [6:0] chan_sel;
  logic [12:0] mem_addr;

  int cyc = 0, n_tests = 0, n_fail = 0;
  localparam int S0 = 204, S1 = S0 + 4096, S2 = S0 + 8192, S3 = S2 + 1504, LAST = S3 + 2500;

  mixed_rate_tdm_sched u0 (.*);

  always #2.5 clk = ~clk;

  function automatic bit fp_level(input int c);
    int starts[4] = '{S0, S1, S2, S3};
    foreach (starts[i]) if (c >= starts[i] - 4 && c < starts[i] + 4) return 1'b1;
    return (c == 53 || c == 54 || c == 3005 || c == 3006);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // behavioural model: frame time since last accepted pulse
  bit m_act, m_rd, m_wr, m_refp;
  int m_t;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_rd = 0; m_wr = 0; m_refp = 1;
    end else begin
      bit hit;
      hit = ref_clk && !m_refp && frame_pulse;
      m_refp = ref_clk;
      if (m_act && m_t == 127 * 32 + 27) m_rd = !m_rd;
      if (m_act && m_t == 7 * 32 + 11)   m_wr = !m_wr;
      if (hit) begin m_act = 1; m_t = 0; end
      else if (m_act) m_t = (m_t + 1) % 4096;
    end
  end

  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      check(acc_valid == 0, "R11 valid", acc_valid, 0);
      check(rd_blk == 0 && wr_blk == 0, "R11 flags", {rd_blk, wr_blk}, 0);
    end else begin
      bit v, w;
      int h, p, k, b, st, ch, ad;
      h = m_t / 32; p = m_t % 32; v = 0; w = 0; k = 0;
      if (m_act && p < 12) begin v = 1; w = 1; k = p; end
      else if (m_act && p >= 16 && p < 28) begin v = 1; k = p - 16; end
      b = w ? (h + 120) % 128 : h;
      if (k < 8) begin
        st = 16 + k; ch = b; ad = (w ? 'hC00 : 'h400) + 8 * b + k;
      end else begin
        st = (b % 4) * 4 + (k - 8); ch = b / 4; ad = (w ? 'h800 : 0) + 16 * ch + st;
      end
      check(rd_blk == m_rd, "R9 rd_blk", rd_blk, m_rd);
      check(wr_blk == m_wr, "R9 wr_blk", wr_blk, m_wr);
      check(acc_valid == v, m_act ? "R3 valid" : "R1 valid", acc_valid, v);
      if (v) begin
        check(acc_write == w, "R3 direction", acc_write, w);
        check(stream_sel == st, k < 8 ? "R4 stream" : "R5 stream", stream_sel, st);
        check(chan_sel == ch, "R6 channel", chan_sel, ch);
        check(mem_addr[11:0] == ad[11:0], "R7 address", mem_addr[11:0], ad[11:0]);
        check(mem_addr[12] == (w ? m_wr : m_rd), "R8 block bit", mem_addr[12], w ? m_wr : m_rd);
      end
      if (cyc == 60)
        check(acc_valid == 0, "R2 pulse off ref edge ignored", acc_valid, 0);
      if (cyc == 3010)
        check(chan_sel == ch, "R2 mid-frame glitch ignored", chan_sel, ch);
      if (cyc == S3 + 1) begin
        check(acc_write == 1 && stream_sel == 16, "R10 restart phase", {acc_write, stream_sel}, 'h30);
        check(chan_sel == 120, "R10 restart channel", chan_sel, 120);
      end
    end
  end

  initial begin
    while (cyc < LAST) begin
      @(negedge clk);
      cyc++;
      ref_clk = ((cyc / 4) % 2) == 1;
      frame_pulse = fp_level(cyc);
      if (cyc == 6) rst_n = 1'b1;
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule